// File: doc/BRIEF.md
# Cascadable serial configuration bitstream memory

This block holds a configuration bitstream and sends it out one bit per clock to a programmable logic device that loads itself from an external serial memory. While the block is selected and not held in rewind, every rising clock edge moves on to the next stored bit. The bit at the current address is always present on the data output while the output is enabled. After the last stored bit has been sent, the block releases its data output and pulls its cascade enable output low. A second instance whose chip enable is wired to that output then takes over, so a chain of devices forms one continuous bitstream.

A combined rewind/output-enable input sends the address counter back to zero and disables the data output. Its active level is chosen by a polarity input. The same pin is used to rewind the whole chain after configuration. If the pin is tied inactive, each device keeps its position. When chip enable is high the block is in standby and its output is high impedance. Driving the programming select input low disables the serial read path. The programming-mode write port is then used to load the bit array.

Top module: `cfg_bitstream_mem`

## Requirements
- R1: While chip enable is low, programming select is high, rewind is inactive and the block is not exhausted, data_oe_o is 1 and data_o equals the stored bit at the current address. Each rising clock edge then advances the address by one, starting from address 0.
- R2: The clock edge that follows the output of the last stored bit (address DEPTH-1) drives ceo_no low and data_oe_o low.
- R3: When ceo_no of one instance feeds ce_ni of a second instance, the second instance drives its stored bits in the cycles that follow, so the two form one continuous stream of 2*DEPTH bits. data_oe_o is never 1 while ceo_no is low.
- R4: A rising clock edge with rewind active sets the address to 0 and returns ceo_no high. data_oe_o is 0 while rewind is active.
- R5: Rewind is active when reset_oe_i equals rst_pol_i: rst_pol_i=1 gives an active-high pin and rst_pol_i=0 gives an active-low pin.
- R6: When ce_ni is 1, data_oe_o is 0 and ceo_no is 1, and the address holds.
- R7: When prog_ni is 0, data_oe_o is 0 and the address holds. Writes through wr_en_i take effect only in this mode.
- R8: Once the block is exhausted, the address does not wrap and data_oe_o stays 0 on further clocks until a rewind.
- R9: A write with prog_ni high leaves the stored bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the counter state |
| ce_ni | input | 1 | Active-low chip enable |
| reset_oe_i | input | 1 | Combined rewind / output-enable pin |
| rst_pol_i | input | 1 | Level of reset_oe_i that means rewind |
| prog_ni | input | 1 | Low selects programming mode |
| wr_en_i | input | 1 | Bit-array write strobe (programming mode only) |
| wr_addr_i | input | AW | Write address |
| wr_bit_i | input | 1 | Write data |
| data_o | output | 1 | Serial data value |
| data_oe_o | output | 1 | Tri-state enable for data_o |
| ceo_no | output | 1 | Active-low cascade enable to the next device |

## Verification
The bench chains two 16-bit instances and walks the full 32-bit stream twice, once with each rewind polarity. It checks on every clock which device drives and which bit it drives. A handoff that is one clock late or one clock early therefore shows up as a wrong driver or a doubled bit. A counter that wraps instead of saturating would restart the stream after the exhaustion point. A counter that advances during standby or programming mode would skip the bit that was current when the pause began. A reversed polarity decode would rewind on the wrong level. A write port that is open outside programming mode would corrupt a stored bit.

// File: rtl/cfg_mem_pkg.sv
package cfg_mem_pkg;
  function automatic logic rewind_active(input logic pol, input logic pin);
    return pin == pol;
  endfunction
endpackage

// File: rtl/cfg_bit_array.sv
module cfg_bit_array #(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic          wbit_i,
  input  logic [AW-1:0] raddr_i,
  output logic          rbit_o
);
  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk_i) begin
    if (we_i && (int'(waddr_i) < DEPTH)) bits_q[waddr_i] <= wbit_i;
  end

  assign rbit_o = (int'(raddr_i) < DEPTH) ? bits_q[raddr_i] : 1'b0;
endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr #(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rewind_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      done_o <= 1'b0;
    end else if (rewind_i) begin
      addr_o <= '0;
      done_o <= 1'b0;
    end else if (adv_i && !done_o) begin
      // saturate at terminal count; done marks the handoff
      if (addr_o == LAST) done_o <= 1'b1;
      else                addr_o <= addr_o + 1'b1;
    end
  end

  p_rewind_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_i |=> (addr_o == '0 && !done_o));
  p_advance_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !rewind_i && !done_o && addr_o != LAST) |=> addr_o == $past(addr_o) + 1'b1);
  p_handoff_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !rewind_i && addr_o == LAST) |=> done_o);
  p_saturate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !rewind_i) |=> (done_o && $stable(addr_o)));
  p_pause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !rewind_i) |=> $stable(addr_o));
endmodule

// File: rtl/cfg_out_ctrl.sv
module cfg_out_ctrl
  import cfg_mem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic reset_oe_i,
  input  logic rst_pol_i,
  input  logic prog_ni,
  input  logic done_i,
  output logic rewind_o,
  output logic adv_o,
  output logic oe_o,
  output logic ceo_no
);
  logic selected;

  assign rewind_o = rewind_active(rst_pol_i, reset_oe_i);
  assign selected = !ce_ni && prog_ni && !rewind_o;
  assign adv_o    = selected && !done_i;
  assign oe_o     = selected && !done_i;
  assign ceo_no   = !done_i || ce_ni;

  p_standby_hiz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> (!oe_o && ceo_no));
  p_prog_hiz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_ni |-> !oe_o);
  p_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ceo_no |-> !oe_o);
  p_rewind_hiz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reset_oe_i == rst_pol_i) |-> !oe_o);
endmodule

// File: rtl/cfg_bitstream_mem.sv
module cfg_bitstream_mem #(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          reset_oe_i,
  input  logic          rst_pol_i,
  input  logic          prog_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_bit_i,
  output logic          data_o,
  output logic          data_oe_o,
  output logic          ceo_no
);
  logic [AW-1:0] addr;
  logic          done, rewind, adv, rbit;

  cfg_out_ctrl u_ctrl (
    .clk_i, .rst_ni, .ce_ni, .reset_oe_i, .rst_pol_i, .prog_ni,
    .done_i(done), .rewind_o(rewind), .adv_o(adv), .oe_o(data_oe_o), .ceo_no
  );

  cfg_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk_i, .rst_ni, .rewind_i(rewind), .adv_i(adv), .addr_o(addr), .done_o(done)
  );

  cfg_bit_array #(.DEPTH(DEPTH)) u_arr (
    .clk_i, .we_i(wr_en_i && !prog_ni), .waddr_i(wr_addr_i), .wbit_i(wr_bit_i),
    .raddr_i(addr), .rbit_o(rbit)
  );

  assign data_o = data_oe_o ? rbit : 1'b0;

  p_drive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && prog_ni && !rewind && !done) |-> data_oe_o);
endmodule

// File: tb/cfg_bitstream_mem_test.sv
module cfg_bitstream_mem_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce0_n = 1'b0;
  logic reset_oe = 1'b1;
  logic rst_pol = 1'b1;
  logic prog_n = 1'b0;
  logic [1:0] wr_en = 2'b00;
  logic [AW-1:0] wr_addr = '0;
  logic wr_bit = 1'b0;
  logic d0, oe0, ceo0, d1, oe1, ceo1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_bitstream_mem #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce0_n), .reset_oe_i(reset_oe),
    .rst_pol_i(rst_pol), .prog_ni(prog_n), .wr_en_i(wr_en[0]),
    .wr_addr_i(wr_addr), .wr_bit_i(wr_bit),
    .data_o(d0), .data_oe_o(oe0), .ceo_no(ceo0)
  );

  cfg_bitstream_mem #(.DEPTH(DEPTH)) uut_b (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ceo0), .reset_oe_i(reset_oe),
    .rst_pol_i(rst_pol), .prog_ni(prog_n), .wr_en_i(wr_en[1]),
    .wr_addr_i(wr_addr), .wr_bit_i(wr_bit),
    .data_o(d1), .data_oe_o(oe1), .ceo_no(ceo1)
  );

  function automatic logic pat(input int dev, input int a);
    return logic'((((a * 13 + dev * 7) >> 2) ^ a) & 1);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // walk the chained stream from its start; k indexes the global bit
  task automatic run_stream();
    for (int k = 0; k < 2 * DEPTH; k++) begin
      check("R3 dev0 drives", int'(oe0), int'(k < DEPTH));
      check("R3 dev1 drives", int'(oe1), int'(k >= DEPTH));
      check("R2 ceo0 handoff clock", int'(ceo0), int'(k < DEPTH));
      if (k < DEPTH) check("R1 stream bit dev0", int'(d0), int'(pat(0, k)));
      else           check("R3 stream bit dev1", int'(d1), int'(pat(1, k - DEPTH)));
      step();
    end
    check("R2 dev0 released", int'(oe0), 0);
    check("R2 dev1 released", int'(oe1), 0);
    check("R2 ceo1 low", int'(ceo1), 0);
    for (int j = 0; j < 3; j++) step();
    check("R8 no wrap dev0", int'(oe0), 0);
    check("R8 no wrap dev1", int'(oe1), 0);
    check("R8 ceo1 stays low", int'(ceo1), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    rst_ni = 1'b1;
    #1;
    check("R4 reset ceo0", int'(ceo0), 1);
    check("R4 reset ceo1", int'(ceo1), 1);
    check("R7 reset oe0", int'(oe0), 0);

    for (int d = 0; d < 2; d++)
      for (int a = 0; a < DEPTH; a++) begin
        wr_addr = AW'(a);
        wr_bit = pat(d, a);
        wr_en = 2'(1 << d);
        step();
        wr_en = 2'b00;
      end

    prog_n = 1'b1;
    reset_oe = 1'b0;
    #1;
    run_stream();

    // rewind, active-high pin
    reset_oe = 1'b1;
    step();
    check("R4 rewind ceo0", int'(ceo0), 1);
    check("R4 rewind ceo1", int'(ceo1), 1);
    check("R4 oe off in rewind", int'(oe0), 0);
    reset_oe = 1'b0;
    #1;
    check("R4 bit0 after rewind", int'(d0), int'(pat(0, 0)));
    check("R4 oe after rewind", int'(oe0), 1);
    for (int k = 0; k < 5; k++) begin
      check("R1 restart bits", int'(d0), int'(pat(0, k)));
      step();
    end

    // standby holds position
    ce0_n = 1'b1;
    #1;
    check("R6 standby oe0", int'(oe0), 0);
    check("R6 standby oe1", int'(oe1), 0);
    check("R6 standby ceo0", int'(ceo0), 1);
    for (int j = 0; j < 3; j++) step();
    ce0_n = 1'b0;
    #1;
    check("R6 address held", int'(d0), int'(pat(0, 5)));

    // programming mode holds position
    prog_n = 1'b0;
    #1;
    check("R7 prog oe0", int'(oe0), 0);
    step();
    step();
    prog_n = 1'b1;
    #1;
    check("R7 address held", int'(d0), int'(pat(0, 5)));

    // write outside programming mode is ignored (standby keeps the address)
    ce0_n = 1'b1;
    wr_addr = AW'(5);
    wr_bit = ~pat(0, 5);
    wr_en = 2'b01;
    step();
    wr_en = 2'b00;
    ce0_n = 1'b0;
    #1;
    check("R9 stored bit kept", int'(d0), int'(pat(0, 5)));

    // active-low polarity
    rst_pol = 1'b0;
    reset_oe = 1'b1;
    #1;
    check("R5 high inactive when pol=0", int'(oe0), 1);
    step();
    check("R5 advance when pol=0", int'(d0), int'(pat(0, 6)));
    reset_oe = 1'b0;
    #1;
    check("R5 low active oe off", int'(oe0), 0);
    step();
    reset_oe = 1'b1;
    #1;
    check("R5 rewind bit0", int'(d0), int'(pat(0, 0)));
    check("R5 rewind ceo0", int'(ceo0), 1);
    run_stream();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule